// File: doc/BRIEF.md
# Latched Output Stage with Global Overrides

This block holds a wide word of shift-stage values in a parallel latch and presents it on a bank of output lanes. A falling edge on an active-low strobe copies every stage bit into the latch in one shot. At all other times the latch keeps its contents. Because of this, a new word can be shifted in upstream while the previous word is still on display.

After the latch, three global controls act on every lane at once. Each lane is presented as a data bit paired with a drive enable. A high-impedance request releases every lane. A force-low request drives every lane low. A force-high request drives every lane high. When none of these is active, each lane shows its latched bit unchanged. The controls have a fixed priority: high-impedance wins over force-low, force-low wins over force-high, and force-high wins over latched data. None of the controls alters the latch.

The strobe is sampled on the system clock. A falling edge is the first clock sample at which the strobe reads low after a sample at which it read high.

Top module: `hold_drive_top`

## Requirements
- R1: A capture happens when the clock samples `strobe_ni` low and the sample one clock earlier was high. At that same rising clock edge, every bit of `stage_i` is written to the latch, and the new word appears on the lanes right after that edge.
- R2: When the strobe stays high, stays low, or rises, the latch holds its contents whatever `stage_i` does.
- R3: With `hz_i` = 1, every bit of `out_en_o` is 0, whatever the blanking inputs or the data are.
- R4: With `hz_i` = 0 and `blank_lo_ni` = 0, every lane is enabled and driven 0. This holds even when `blank_hi_ni` is also 0.
- R5: With `hz_i` = 0, `blank_lo_ni` = 1 and `blank_hi_ni` = 0, every lane is enabled and driven 1.
- R6: With `hz_i` = 0 and both blanking inputs at 1, every lane is enabled and `out_data_o[i]` equals latch bit i: a stored 1 drives 1 and a stored 0 drives 0.
- R7: The overrides never change the latch. When they are released, the lanes show the last captured word again.
- R8: Reset clears the latch to all zeros. After reset, the strobe must be sampled high before the first capture can happen, so a strobe held low through reset captures nothing.
- R9: A strobe falling edge still captures while any override is active. The captured word shows on the lanes once the overrides are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; the strobe is sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stage_i | input | 96 | Parallel values from the shift stages |
| strobe_ni | input | 1 | Capture strobe, active low; capture happens on its falling edge |
| hz_i | input | 1 | When 1, releases all lanes (high impedance) |
| blank_lo_ni | input | 1 | When 0, forces all lanes low |
| blank_hi_ni | input | 1 | When 0, forces all lanes high |
| out_data_o | output | 96 | Level driven on each lane |
| out_en_o | output | 96 | Drive enable for each lane; 0 means high impedance |

## Verification
If the latch holds a wrong bit, it shows on the matching lane as soon as all overrides are released. There is no delay, because the lanes are combinational from the latch. An extra or missed capture shows one clock after the strobe sample that caused it: the lanes either change early or keep stale data. A priority fault changes the lane levels in the same cycle the controls change. The bench therefore walks all eight control combinations against two complementary data words, and it samples the lanes both inside and after each override.

// File: rtl/hold_drive_pkg.sv
package hold_drive_pkg;
  localparam int unsigned LANES = 96;

  typedef enum logic [1:0] {
    MODE_HIZ  = 2'd0,
    MODE_LOW  = 2'd1,
    MODE_HIGH = 2'd2,
    MODE_DATA = 2'd3
  } lane_mode_e;
endpackage

// File: rtl/strobe_fall_det.sv
module strobe_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_ni,
  output logic fall_o
);
  logic strobe_q;

  // reset low: strobe must be seen high before a capture can arm
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= strobe_ni;
  end

  assign fall_o = strobe_q & ~strobe_ni;

  a_r1_fall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/hold_latch.sv
module hold_latch #(
  parameter int unsigned WIDTH = 96
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] latch_o
);
  logic [WIDTH-1:0] latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    latch_q <= '0;
    else if (cap_i) latch_q <= data_i;
  end

  assign latch_o = latch_q;

  a_r1_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> latch_q == $past(data_i));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(latch_q));
endmodule

// File: rtl/lane_ctrl.sv
module lane_ctrl
  import hold_drive_pkg::*;
#(
  parameter int unsigned WIDTH = 96
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] latch_i,
  input  logic             hz_i,
  input  logic             blank_lo_ni,
  input  logic             blank_hi_ni,
  output logic [WIDTH-1:0] out_data_o,
  output logic [WIDTH-1:0] out_en_o
);
  lane_mode_e mode;

  // fixed priority: hz > force-low > force-high > data
  always_comb begin
    if (hz_i)              mode = MODE_HIZ;
    else if (!blank_lo_ni) mode = MODE_LOW;
    else if (!blank_hi_ni) mode = MODE_HIGH;
    else                   mode = MODE_DATA;
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    assign out_en_o[g]   = (mode != MODE_HIZ);
    assign out_data_o[g] = (mode == MODE_HIGH) | ((mode == MODE_DATA) & latch_i[g]);
  end

  a_r3_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hz_i |-> out_en_o == '0);
  a_r4_force_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hz_i && !blank_lo_ni) |-> (out_en_o == '1 && out_data_o == '0));
  a_r5_force_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hz_i && blank_lo_ni && !blank_hi_ni) |-> (out_en_o == '1 && out_data_o == '1));
  a_r6_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hz_i && blank_lo_ni && blank_hi_ni) |-> (out_en_o == '1 && out_data_o == latch_i));
endmodule

// File: rtl/hold_drive_top.sv
module hold_drive_top
  import hold_drive_pkg::*;
#(
  parameter int unsigned WIDTH = LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] stage_i,
  input  logic             strobe_ni,
  input  logic             hz_i,
  input  logic             blank_lo_ni,
  input  logic             blank_hi_ni,
  output logic [WIDTH-1:0] out_data_o,
  output logic [WIDTH-1:0] out_en_o
);
  logic             cap;
  logic [WIDTH-1:0] latch_w;

  strobe_fall_det u_fall (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_ni (strobe_ni),
    .fall_o    (cap)
  );

  hold_latch #(.WIDTH(WIDTH)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .data_i  (stage_i),
    .latch_o (latch_w)
  );

  lane_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .latch_i     (latch_w),
    .hz_i        (hz_i),
    .blank_lo_ni (blank_lo_ni),
    .blank_hi_ni (blank_hi_ni),
    .out_data_o  (out_data_o),
    .out_en_o    (out_en_o)
  );
endmodule

// File: tb/hold_drive_top_tb_top.sv
module hold_drive_top_tb_top;
  localparam int unsigned W      = 96;
  localparam time         CLK_PER = 10ns;
  localparam logic [W-1:0] PAT_A = {24{4'hA}} ^ {12{8'h3C}};
  localparam logic [W-1:0] PAT_B = ~PAT_A;
  // {hz, blank_lo_n, blank_hi_n, pattern_sel, expected_mode}; mode 0=hiz 1=low 2=high 3=data
  localparam logic [5:0] VEC [16] = '{
    6'b0000_01, 6'b0001_01, 6'b0010_01, 6'b0011_01,
    6'b0100_10, 6'b0101_10, 6'b0110_11, 6'b0111_11,
    6'b1000_00, 6'b1001_00, 6'b1010_00, 6'b1011_00,
    6'b1100_00, 6'b1101_00, 6'b1110_00, 6'b1111_00
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] stage = '0;
  logic         strobe_n = 1'b0;
  logic         hz = 1'b0, blo_n = 1'b1, bhi_n = 1'b1;
  logic [W-1:0] odata, oen;
  int           checks = 0, errors = 0;
  logic         done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  hold_drive_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .stage_i(stage), .strobe_ni(strobe_n),
    .hz_i(hz), .blank_lo_ni(blo_n), .blank_hi_ni(bhi_n),
    .out_data_o(odata), .out_en_o(oen)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [W-1:0] exp_d, logic [W-1:0] exp_e);
    checks++;
    if (oen !== exp_e || ((odata ^ exp_d) & exp_e) !== '0) begin
      errors++;
      $display("FAIL %s: data=%h en=%h expected data=%h en=%h", req, odata, oen, exp_d, exp_e);
    end
  endtask

  task automatic capture(logic [W-1:0] d);
    stage = d; strobe_n = 1'b1; tick();
    strobe_n = 1'b0; tick();
    strobe_n = 1'b1; stage = ~d; tick();
  endtask

  initial begin
    #(CLK_PER * 100000);
    errors++; checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R8: strobe held low through reset, then released while still low
    stage = PAT_A;
    repeat (3) tick();
    rst_n = 1'b1;
    tick(); tick();
    check("R8 reset clears latch, low strobe does not capture", '0, '1);

    // R1: falling edge captures; visible right after that edge
    stage = PAT_A; strobe_n = 1'b1; tick();
    strobe_n = 1'b0; #1;
    check("R1 no change before capturing edge", '0, '1);
    tick();
    check("R1 capture at falling-edge sample", PAT_A, '1);

    // R2: held low, new stage data ignored
    stage = PAT_B; tick(); tick();
    check("R2 hold while strobe stays low", PAT_A, '1);
    strobe_n = 1'b1; tick();
    check("R2 hold on strobe rise", PAT_A, '1);
    stage = '1; tick(); tick();
    check("R2 hold while strobe stays high", PAT_A, '1);

    // table: every control combination with both patterns
    for (int i = 0; i < 16; i++) begin
      logic [5:0]   v;
      logic [W-1:0] pat;
      logic [W-1:0] ed, ee;
      v   = VEC[i];
      pat = v[2] ? PAT_B : PAT_A;
      hz = v[5]; blo_n = v[4]; bhi_n = v[3];
      capture(pat); // R9: capture under overrides
      case (v[1:0])
        2'd0:    begin ed = '0;  ee = '0; end
        2'd1:    begin ed = '0;  ee = '1; end
        2'd2:    begin ed = '1;  ee = '1; end
        default: begin ed = pat; ee = '1; end
      endcase
      check(v[1:0] == 2'd0 ? "R3 hiz priority" : v[1:0] == 2'd1 ? "R4 force-low priority" :
            v[1:0] == 2'd2 ? "R5 force-high" : "R6 follow latch", ed, ee);
      hz = 1'b0; blo_n = 1'b1; bhi_n = 1'b1; #1;
      check("R7 R9 latch intact after release", pat, '1);
    end

    // R7: toggling overrides with no strobe keeps contents
    capture(PAT_B);
    hz = 1'b1; tick(); blo_n = 1'b0; tick(); hz = 1'b0; bhi_n = 1'b0; tick();
    check("R4 force-low beats force-high", '0, '1);
    blo_n = 1'b1; tick();
    check("R5 force-high alone", '1, '1);
    bhi_n = 1'b1; tick();
    check("R7 last word returns", PAT_B, '1);

    // R8: asynchronous reset mid-run
    rst_n = 1'b0; #1;
    check("R8 async reset clears", '0, '1);
    tick(); rst_n = 1'b1; tick();
    check("R8 stays clear after release", '0, '1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule